// File: doc/BRIEF.md
# Storage Data Unit Statistics Counter

This block keeps the traffic statistics that a storage controller reports to its host. Each time a read or write command completes, the controller presents the opcode, the number of bytes moved and whether the command succeeded. For every successful read or write the block counts one command in that direction. It also converts the byte count into 512-byte blocks and turns the blocks into data units of one thousand blocks each. A partial group of blocks counts as a whole unit.

The read side and the write side each have their own remainder register. This register starts one short of a full unit, so the first block of any new group already produces a unit. When a remainder reaches a full unit, the block moves it into the unit counter one unit per clock and raises `busy` until the remainder is below a full unit again. No command is accepted while `busy` is high. The four counters are registered outputs, so a log reader can take all of them in one cycle.

Top module: `du_stat_counter`

## Requirements
- R1: After reset, all four counters are zero and `busy` is low.
- R2: A command with opcode 8'h01 (write), `cmd_valid` high, `cmd_ok` high and `busy` low adds one to `wr_cmds` at the next clock edge. `rd_cmds` does not change.
- R3: A command with opcode 8'h02 (read), accepted under the same conditions, adds one to `rd_cmds` at the next clock edge. `wr_cmds` does not change.
- R4: The block count of a command is `cmd_bytes` divided by 512, rounded down. Once the block is idle, each direction's unit counter equals the total blocks accepted in that direction divided by 1000, rounded up. For example, 1 to 1000 blocks give one unit and 2001 to 3000 blocks give three units. Commands of fewer than 512 bytes are counted as commands but add no blocks.
- R5: The unit counters change only while `busy` is high, by at most one per clock. `busy` is high exactly while either remainder holds 1000 or more blocks. It rises in the cycle after a command that brings a remainder to that level.
- R6: A command presented while `busy` is high has no effect on any counter.
- R7: A command presented with `cmd_ok` low has no effect on any counter.
- R8: An opcode other than 8'h01 or 8'h02 has no effect on any counter.
- R9: Every counter wraps silently from 2^CNT_W-1 to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A completed command is presented this cycle |
| cmd_opcode | input | OPC_W | Opcode of the completed command |
| cmd_bytes | input | BYTE_W | Bytes transferred by the command |
| cmd_ok | input | 1 | High when the command completed successfully |
| busy | output | 1 | Units are still being moved; new commands are ignored |
| rd_cmds | output | CNT_W | Successful read commands |
| wr_cmds | output | CNT_W | Successful write commands |
| rd_units | output | CNT_W | Read data units |
| wr_units | output | CNT_W | Write data units |

## Verification
The bench builds the block with CNT_W=8, so a few hundred zero-byte writes carry the write command counter through its wrap. It uses BYTE_W=24, which allows transfers of up to 32767 blocks. With these values, busy stretches of dozens of cycles occur, and a read can be presented in the middle of one to show that it is dropped. Both widths keep every scenario short, while the rounding cases at 1000, 1001 and 3000 blocks remain reachable.

// File: rtl/du_stat_counter.sv
module du_stat_counter #(
  parameter int CNT_W     = 64,
  parameter int BYTE_W    = 32,
  parameter int OPC_W     = 8,
  parameter logic [OPC_W-1:0] OPC_WR = 8'h01,
  parameter logic [OPC_W-1:0] OPC_RD = 8'h02,
  parameter int UNIT_BLK  = 1000,
  parameter int BLK_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OPC_W-1:0]  cmd_opcode,
  input  logic [BYTE_W-1:0] cmd_bytes,
  input  logic              cmd_ok,
  output logic              busy,
  output logic [CNT_W-1:0]  rd_cmds,
  output logic [CNT_W-1:0]  wr_cmds,
  output logic [CNT_W-1:0]  rd_units,
  output logic [CNT_W-1:0]  wr_units
);

  localparam int BLK_W  = BYTE_W - BLK_SHIFT;
  localparam int UNIT_W = $clog2(UNIT_BLK);
  localparam int REM_W  = ((BLK_W > UNIT_W) ? BLK_W : UNIT_W) + 1;
  localparam logic [REM_W-1:0] REM_PRESET = REM_W'(UNIT_BLK - 1);
  localparam logic [REM_W-1:0] REM_UNIT   = REM_W'(UNIT_BLK);

  logic [BLK_W-1:0]            blocks;
  logic                        take;
  logic [1:0]                  hit;
  logic [1:0]                  over;
  logic [1:0][CNT_W-1:0]       cmd_cnt;
  logic [1:0][CNT_W-1:0]       unit_cnt;

  assign blocks = cmd_bytes[BYTE_W-1:BLK_SHIFT];
  assign busy   = |over;
  assign take   = cmd_valid & cmd_ok & ~busy;
  assign hit[0] = take & (cmd_opcode == OPC_RD);
  assign hit[1] = take & (cmd_opcode == OPC_WR);

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] cmd_q;
    logic [CNT_W-1:0] unit_q;

    assign over[d] = rem_q >= REM_UNIT;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem_q  <= REM_PRESET;
        cmd_q  <= '0;
        unit_q <= '0;
      end else if (hit[d]) begin
        cmd_q <= cmd_q + 1'b1;
        rem_q <= rem_q + REM_W'(blocks);
      end else if (over[d]) begin
        unit_q <= unit_q + 1'b1;
        rem_q  <= rem_q - REM_UNIT;
      end
    end

    assign cmd_cnt[d]  = cmd_q;
    assign unit_cnt[d] = unit_q;
  end

  assign rd_cmds  = cmd_cnt[0];
  assign wr_cmds  = cmd_cnt[1];
  assign rd_units = unit_cnt[0];
  assign wr_units = unit_cnt[1];

endmodule

// File: rtl/du_stat_counter_chk.sv
module du_stat_counter_chk #(
  parameter int CNT_W  = 64,
  parameter int BYTE_W = 32,
  parameter int OPC_W  = 8,
  parameter logic [OPC_W-1:0] OPC_WR = 8'h01,
  parameter logic [OPC_W-1:0] OPC_RD = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [OPC_W-1:0]  cmd_opcode,
  input logic [BYTE_W-1:0] cmd_bytes,
  input logic              cmd_ok,
  input logic              busy,
  input logic [CNT_W-1:0]  rd_cmds,
  input logic [CNT_W-1:0]  wr_cmds,
  input logic [CNT_W-1:0]  rd_units,
  input logic [CNT_W-1:0]  wr_units
);

  AST_WR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ok && !busy && cmd_opcode == OPC_WR) |=>
    (wr_cmds == $past(wr_cmds) + CNT_W'(1)) && $stable(rd_cmds)); // R2
  AST_RD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ok && !busy && cmd_opcode == OPC_RD) |=>
    (rd_cmds == $past(rd_cmds) + CNT_W'(1)) && $stable(wr_cmds)); // R3
  AST_IDLE_UNITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_units) && $stable(wr_units)); // R5
  AST_UNIT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((wr_units == $past(wr_units)) || (wr_units == $past(wr_units) + CNT_W'(1))) &&
             ((rd_units == $past(rd_units)) || (rd_units == $past(rd_units) + CNT_W'(1)))); // R5
  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_cmds) && $stable(wr_cmds)); // R6
  AST_FAIL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ok && !busy) |=>
    $stable(rd_cmds) && $stable(wr_cmds) && $stable(rd_units) && $stable(wr_units)); // R7
  AST_OTHER_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode != OPC_WR && cmd_opcode != OPC_RD) |=>
    $stable(rd_cmds) && $stable(wr_cmds)); // R8

endmodule

bind du_stat_counter du_stat_counter_chk #(
  .CNT_W(CNT_W), .BYTE_W(BYTE_W), .OPC_W(OPC_W), .OPC_WR(OPC_WR), .OPC_RD(OPC_RD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
  .cmd_bytes(cmd_bytes), .cmd_ok(cmd_ok), .busy(busy), .rd_cmds(rd_cmds),
  .wr_cmds(wr_cmds), .rd_units(rd_units), .wr_units(wr_units)
);

// File: tb/tb_du_stat_counter.sv
module tb_du_stat_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int BYTE_W = 24;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [7:0]        cmd_opcode = '0;
  logic [BYTE_W-1:0] cmd_bytes = '0;
  logic              cmd_ok = 1'b0;
  logic              busy;
  logic [CNT_W-1:0]  rd_cmds, wr_cmds, rd_units, wr_units;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  longint m_rc = 0, m_wc = 0, m_ru = 0, m_wu = 0;
  longint m_rrem = 999, m_wrem = 999;
  longint tot_rblk = 0, tot_wblk = 0;

  du_stat_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_bytes(cmd_bytes), .cmd_ok(cmd_ok), .busy(busy), .rd_cmds(rd_cmds),
    .wr_cmds(wr_cmds), .rd_units(rd_units), .wr_units(wr_units)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint ceil_units(longint blk);
    return (blk + 999) / 1000;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint wrapc(longint v);
    return v % (64'sd1 << CNT_W);
  endfunction

  // Behavioural reference: accepted commands add blocks, otherwise a full unit drains per clock
  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ok && !(m_rrem >= 1000 || m_wrem >= 1000)) begin
        if (cmd_opcode == 8'h01) begin
          m_wc <= m_wc + 1; m_wrem <= m_wrem + (cmd_bytes / 512);
          tot_wblk <= tot_wblk + (cmd_bytes / 512);
        end else if (cmd_opcode == 8'h02) begin
          m_rc <= m_rc + 1; m_rrem <= m_rrem + (cmd_bytes / 512);
          tot_rblk <= tot_rblk + (cmd_bytes / 512);
        end
      end else begin
        if (m_wrem >= 1000) begin m_wu <= m_wu + 1; m_wrem <= m_wrem - 1000; end
        if (m_rrem >= 1000) begin m_ru <= m_ru + 1; m_rrem <= m_rrem - 1000; end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      chk("R2 wr_cmds", wr_cmds, wrapc(m_wc));
      chk("R3 rd_cmds", rd_cmds, wrapc(m_rc));
      chk("R5 wr_units", wr_units, wrapc(m_wu));
      chk("R5 rd_units", rd_units, wrapc(m_ru));
      chk("R5 busy", busy, (m_rrem >= 1000 || m_wrem >= 1000) ? 1 : 0);
    end
    if (cycles == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(logic [7:0] op, longint bytes, logic ok);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_bytes = BYTE_W'(bytes); cmd_ok = ok;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_ok = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    longint base;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 rd_cmds", rd_cmds, 0);
    chk("R1 wr_cmds", wr_cmds, 0);
    chk("R1 rd_units", rd_units, 0);
    chk("R1 wr_units", wr_units, 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    issue(8'h01, 512, 1'b1);
    settle();
    chk("R2 wr_cmds one", wr_cmds, 1);
    chk("R4 one block one unit", wr_units, 1);
    chk("R3 rd untouched", rd_cmds, 0);

    issue(8'h01, 999 * 512, 1'b1);
    settle();
    chk("R4 1000 blocks one unit", wr_units, 1);

    issue(8'h01, 512, 1'b1);
    settle();
    chk("R4 1001 blocks two units", wr_units, 2);

    issue(8'h01, 511, 1'b1);
    settle();
    chk("R4 sub-block command", wr_units, 2);
    chk("R4 sub-block counted", wr_cmds, 4);

    issue(8'h02, 3000 * 512 + 300, 1'b1);
    settle();
    chk("R3 rd_cmds one", rd_cmds, 1);
    chk("R4 3000 blocks three units", rd_units, 3);
    issue(8'h02, 2001 * 512, 1'b1);
    settle();
    chk("R4 5001 blocks six units", rd_units, ceil_units(5001));

    issue(8'h01, 40000 * 512, 1'b0);
    settle();
    chk("R7 failed cmds", wr_cmds, 4);
    chk("R7 failed units", wr_units, 2);

    issue(8'h05, 9000 * 512, 1'b1);
    settle();
    chk("R8 other opcode wr", wr_cmds, 4);
    chk("R8 other opcode rd", rd_cmds, 2);
    chk("R8 other opcode units", rd_units + wr_units, 8);

    issue(8'h01, 32767 * 512, 1'b1);
    chk("R5 busy after big write", busy, 1);
    cmd_valid = 1'b1; cmd_opcode = 8'h02; cmd_bytes = BYTE_W'(5000 * 512); cmd_ok = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_ok = 1'b0;
    chk("R6 read while busy", rd_cmds, 2);
    settle();
    chk("R6 read units unchanged", rd_units, 6);
    chk("R4 big write units", wr_units, wrapc(ceil_units(tot_wblk)));

    base = wr_cmds;
    for (int i = 0; i < 256; i++) issue(8'h01, 0, 1'b1);
    settle();
    chk("R9 wr_cmds wrap", wr_cmds, base);
    chk("R9 wr_cmds model", wr_cmds, wrapc(m_wc));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule